// File: doc/BRIEF.md
# Cell Buffer Free-Address Manager with Per-Port Reserve and Common Pool

This block keeps track of which slots of a cell buffer are free. The buffer's address range is split into one reserved region per output port and one common region that follows them. Each region has its own free list, held as a FIFO of addresses. A client asks for a slot by giving a destination port. The manager hands out an address from that port's reserved region while one is left, and otherwise takes one from the common region. When both are exhausted it refuses the request and the cell is dropped. When a cell leaves the buffer, its address is given back. The manager works out from the address value which free list it belongs to.

After reset the block runs a fill sequence that loads every address of every region into its free list. The fill writes all lists in parallel, one entry per cycle. While it runs, requests are refused and returned addresses are ignored. Per-list free counts are exported so that occupancy can be watched. One request and one return are accepted in every cycle, and both may touch the same list.

Top module: `cbm_addr_mgr`

## Requirements
- R1: After reset is released, `init_done` rises within MAX_DEPTH+1 cycles, where MAX_DEPTH is the larger of PRIV_DEPTH and SHARED_DEPTH. From that point each reserved count reads PRIV_DEPTH and the common count reads SHARED_DEPTH. While reset is held, `alloc_gnt`, `alloc_rej` and `init_done` are 0.
- R2: A request made while `init_done` is 0 is answered with `alloc_rej`. A return made while `init_done` is 0 changes no count.
- R3: A request for port k, when reserved list k is not empty, is granted with `alloc_shared`=0. The address lies in [k*PRIV_DEPTH, (k+1)*PRIV_DEPTH).
- R4: A request for port k, when reserved list k is empty and the common list is not, is granted with `alloc_shared`=1. The address lies in [NUM_PORTS*PRIV_DEPTH, NUM_PORTS*PRIV_DEPTH+SHARED_DEPTH).
- R5: A request is rejected when reserved list k and the common list are both empty. A rejected request changes no count.
- R6: Every request gets exactly one response, `alloc_gnt` or `alloc_rej`, in the cycle after it is sampled. No response appears in a cycle that follows a cycle without a request.
- R7: A returned address below NUM_PORTS*PRIV_DEPTH goes to reserved list (address / PRIV_DEPTH). Any other address goes to the common list.
- R8: The choice between lists uses the counts from before the cycle. A request and a return that hit the same non-empty list leave its count unchanged. A return into an empty reserved list does not serve a request for that port made in the same cycle, so the request falls back to the common list.
- R9: Each free count equals the number of addresses in its list and updates in the cycle after the request or return that changed it.
- R10: Each list hands out addresses in first-in first-out order. After the fill, reserved list k hands out k*PRIV_DEPTH, k*PRIV_DEPTH+1, and so on, and only then any address returned to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request one free address |
| alloc_port | input | PORT_W | Destination port of the request, binary |
| rel_valid | input | 1 | Return one address |
| rel_addr | input | ADDR_W | Address being returned |
| init_done | output | 1 | Fill sequence finished; block accepts traffic |
| alloc_gnt | output | 1 | Request granted, one cycle after the request |
| alloc_rej | output | 1 | Request refused, one cycle after the request |
| alloc_addr | output | ADDR_W | Granted address, valid with `alloc_gnt` |
| alloc_shared | output | 1 | Granted address came from the common region |
| priv_free_cnt | output | NUM_PORTS*CNT_W | Free count of each reserved list; port k at bits [k*CNT_W +: CNT_W] |
| shared_free_cnt | output | CNT_W | Free count of the common list |

## Verification
The assertions assume that only an address currently held by a client is returned, and that it is returned once. Under that rule no list can overflow, and the count bounds hold. The assertions also assume that `alloc_port` stays below NUM_PORTS. The stimulus keeps to both rules. It draws `alloc_port` in range and releases only addresses taken from its own list of outstanding grants, removing each one when it is returned. The one exception is during the fill, when the bench deliberately returns arbitrary addresses; these are meant to be ignored.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Outcome of the list selection for one request
  typedef enum logic [1:0] {
    ALLOC_NONE   = 2'd0,
    ALLOC_PRIV   = 2'd1,
    ALLOC_SHARED = 2'd2,
    ALLOC_REJECT = 2'd3
  } alloc_src_e;

endpackage

// File: rtl/cbm_free_fifo.sv
// Free-address list: circular buffer with simultaneous push and pop.
module cbm_free_fifo #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head,
  output logic [CNT_W-1:0]  count
);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rd_d  = pop  ? ptr_inc(rd_q) : rd_q;
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage is not reset; the fill sequence writes every slot.
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q] <= push_addr;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/cbm_init_seq.sv
// Fill sequencer: steps an index once per cycle after reset, then signals done.
module cbm_init_seq #(
  parameter int STEPS = 16,
  localparam int IDX_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             done,
  output logic [IDX_W-1:0] idx
);

  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  always_comb begin
    last   = (idx_q == IDX_W'(STEPS - 1));
    done_d = done_q | last;
    idx_d  = (!done_q && !last) ? idx_q + IDX_W'(1) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign done = done_q;
  assign idx  = idx_q;

endmodule

// File: rtl/cbm_addr_mgr.sv
// Free-address manager: per-port reserved lists with a common fallback list.
module cbm_addr_mgr
  import cbm_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int PRIV_DEPTH   = 8,
  parameter int SHARED_DEPTH = 16,
  localparam int TOTAL     = NUM_PORTS * PRIV_DEPTH + SHARED_DEPTH,
  localparam int ADDR_W    = $clog2(TOTAL),
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int MAX_DEPTH = (PRIV_DEPTH > SHARED_DEPTH) ? PRIV_DEPTH : SHARED_DEPTH,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_req,
  input  logic [PORT_W-1:0]          alloc_port,
  input  logic                       rel_valid,
  input  logic [ADDR_W-1:0]          rel_addr,
  output logic                       init_done,
  output logic                       alloc_gnt,
  output logic                       alloc_rej,
  output logic [ADDR_W-1:0]          alloc_addr,
  output logic                       alloc_shared,
  output logic [NUM_PORTS*CNT_W-1:0] priv_free_cnt,
  output logic [CNT_W-1:0]           shared_free_cnt
);

  localparam int SH_BASE = NUM_PORTS * PRIV_DEPTH;
  localparam int IDX_W   = $clog2(MAX_DEPTH);

  logic             init_busy;
  logic [IDX_W-1:0] init_idx;

  logic [NUM_PORTS-1:0] priv_push, priv_pop, priv_empty, rel_hit;
  logic [ADDR_W-1:0]    priv_push_addr [NUM_PORTS];
  logic [ADDR_W-1:0]    priv_head      [NUM_PORTS];
  logic [CNT_W-1:0]     priv_cnt       [NUM_PORTS];

  logic              sh_push, sh_pop, sh_empty;
  logic [ADDR_W-1:0] sh_push_addr, sh_head;
  logic [CNT_W-1:0]  sh_cnt;

  logic              rel_ok, port_ok, req_priv_empty;
  alloc_src_e        src_d;
  logic [ADDR_W-1:0] addr_d;

  logic              gnt_q, gnt_d, rej_q, rej_d, shared_q, shared_d, addr_en;
  logic [ADDR_W-1:0] addr_q;

  cbm_init_seq #(.STEPS(MAX_DEPTH)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (init_done),
    .idx   (init_idx)
  );

  assign init_busy = !init_done;
  assign rel_ok    = rel_valid && init_done;

  // One reserved list per output port
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_priv
    assign rel_hit[k] = (int'(rel_addr) >= k * PRIV_DEPTH) &&
                        (int'(rel_addr) < (k + 1) * PRIV_DEPTH);
    assign priv_push[k] = init_busy ? (int'(init_idx) < PRIV_DEPTH)
                                    : (rel_ok && rel_hit[k]);
    assign priv_push_addr[k] = init_busy ? ADDR_W'(k * PRIV_DEPTH + int'(init_idx))
                                         : rel_addr;
    assign priv_pop[k] = (src_d == ALLOC_PRIV) && (int'(alloc_port) == k);

    cbm_free_fifo #(
      .DEPTH  (PRIV_DEPTH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (priv_push[k]),
      .push_addr (priv_push_addr[k]),
      .pop       (priv_pop[k]),
      .head      (priv_head[k]),
      .count     (priv_cnt[k])
    );

    assign priv_empty[k] = (priv_cnt[k] == '0);
    assign priv_free_cnt[k*CNT_W +: CNT_W] = priv_cnt[k];
  end

  // Common list
  assign sh_push      = init_busy ? (int'(init_idx) < SHARED_DEPTH)
                                  : (rel_ok && !(|rel_hit));
  assign sh_push_addr = init_busy ? ADDR_W'(SH_BASE + int'(init_idx)) : rel_addr;
  assign sh_pop       = (src_d == ALLOC_SHARED);

  cbm_free_fifo #(
    .DEPTH  (SHARED_DEPTH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sh_push),
    .push_addr (sh_push_addr),
    .pop       (sh_pop),
    .head      (sh_head),
    .count     (sh_cnt)
  );

  assign sh_empty        = (sh_cnt == '0);
  assign shared_free_cnt = sh_cnt;

  // List selection for the current request (uses counts before this edge)
  always_comb begin
    port_ok        = int'(alloc_port) < NUM_PORTS;
    req_priv_empty = port_ok ? priv_empty[alloc_port] : 1'b1;
    if (!alloc_req)                src_d = ALLOC_NONE;
    else if (!init_done || !port_ok) src_d = ALLOC_REJECT;
    else if (!req_priv_empty)      src_d = ALLOC_PRIV;
    else if (!sh_empty)            src_d = ALLOC_SHARED;
    else                           src_d = ALLOC_REJECT;
    addr_d   = (src_d == ALLOC_PRIV && port_ok) ? priv_head[alloc_port] : sh_head;
    gnt_d    = (src_d == ALLOC_PRIV) || (src_d == ALLOC_SHARED);
    rej_d    = (src_d == ALLOC_REJECT);
    shared_d = (src_d == ALLOC_SHARED);
    addr_en  = gnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q    <= 1'b0;
      rej_q    <= 1'b0;
      shared_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      gnt_q    <= gnt_d;
      rej_q    <= rej_d;
      shared_q <= shared_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign alloc_gnt    = gnt_q;
  assign alloc_rej    = rej_q;
  assign alloc_shared = shared_q;
  assign alloc_addr   = addr_q;

endmodule

// File: rtl/cbm_addr_mgr_chk.sv
// Property checker for cbm_addr_mgr, attached by bind.
module cbm_addr_mgr_chk #(
  parameter int NUM_PORTS    = 4,
  parameter int PRIV_DEPTH   = 8,
  parameter int SHARED_DEPTH = 16,
  parameter int ADDR_W       = 6,
  parameter int PORT_W       = 2,
  parameter int CNT_W        = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_req,
  input logic [PORT_W-1:0]          alloc_port,
  input logic                       rel_valid,
  input logic [ADDR_W-1:0]          rel_addr,
  input logic                       init_done,
  input logic                       alloc_gnt,
  input logic                       alloc_rej,
  input logic [ADDR_W-1:0]          alloc_addr,
  input logic                       alloc_shared,
  input logic [NUM_PORTS*CNT_W-1:0] priv_free_cnt,
  input logic [CNT_W-1:0]           shared_free_cnt
);

  localparam int SH_BASE = NUM_PORTS * PRIV_DEPTH;

  logic [CNT_W-1:0] req_cnt;
  assign req_cnt = priv_free_cnt[int'(alloc_port)*CNT_W +: CNT_W];

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !alloc_gnt && !alloc_rej && !init_done); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R1

  AST_EARLY_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !init_done |=> alloc_rej); // R2

  AST_PRIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && !alloc_shared |->
      (int'(alloc_addr) >= $past(int'(alloc_port)) * PRIV_DEPTH) &&
      (int'(alloc_addr) < ($past(int'(alloc_port)) + 1) * PRIV_DEPTH)); // R3

  AST_SHARED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && alloc_shared |->
      (int'(alloc_addr) >= SH_BASE) && (int'(alloc_addr) < SH_BASE + SHARED_DEPTH)); // R4

  AST_FALLBACK_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && alloc_shared |-> $past(req_cnt) == '0); // R4

  AST_REJ_ONLY_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_rej && $past(init_done) |-> $past(req_cnt) == '0 && $past(shared_free_cnt) == '0); // R5

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (alloc_gnt != alloc_rej)); // R6

  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !alloc_gnt && !alloc_rej); // R6

  AST_SHARED_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(shared_free_cnt) <= SHARED_DEPTH); // R9

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_bound
    AST_PRIV_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(priv_free_cnt[k*CNT_W +: CNT_W]) <= PRIV_DEPTH); // R9
  end

endmodule

bind cbm_addr_mgr cbm_addr_mgr_chk #(
  .NUM_PORTS    (NUM_PORTS),
  .PRIV_DEPTH   (PRIV_DEPTH),
  .SHARED_DEPTH (SHARED_DEPTH),
  .ADDR_W       (ADDR_W),
  .PORT_W       (PORT_W),
  .CNT_W        (CNT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .alloc_req       (alloc_req),
  .alloc_port      (alloc_port),
  .rel_valid       (rel_valid),
  .rel_addr        (rel_addr),
  .init_done       (init_done),
  .alloc_gnt       (alloc_gnt),
  .alloc_rej       (alloc_rej),
  .alloc_addr      (alloc_addr),
  .alloc_shared    (alloc_shared),
  .priv_free_cnt   (priv_free_cnt),
  .shared_free_cnt (shared_free_cnt)
);

// File: tb/cbm_addr_mgr_tb.sv
`timescale 1ns/1ps
module cbm_addr_mgr_tb;

  localparam int NP  = 4;
  localparam int PD  = 8;
  localparam int SD  = 16;
  localparam int TOT = NP * PD + SD;
  localparam int SHB = NP * PD;
  localparam int AW  = 6;
  localparam int PW  = 2;
  localparam int CW  = 5;

  logic          clk, rst_n;
  logic          alloc_req, rel_valid;
  logic [PW-1:0] alloc_port;
  logic [AW-1:0] rel_addr;
  logic          init_done, alloc_gnt, alloc_rej, alloc_shared;
  logic [AW-1:0] alloc_addr;
  logic [NP*CW-1:0] priv_free_cnt;
  logic [CW-1:0]    shared_free_cnt;

  cbm_addr_mgr #(.NUM_PORTS(NP), .PRIV_DEPTH(PD), .SHARED_DEPTH(SD)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_port(alloc_port),
    .rel_valid(rel_valid), .rel_addr(rel_addr), .init_done(init_done),
    .alloc_gnt(alloc_gnt), .alloc_rej(alloc_rej), .alloc_addr(alloc_addr),
    .alloc_shared(alloc_shared), .priv_free_cnt(priv_free_cnt),
    .shared_free_cnt(shared_free_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model of the free lists
  int pm [NP][PD];
  int prd [NP];
  int pcnt [NP];
  int sm [SD];
  int srd, scnt;
  bit model_on;
  int outl [TOT];
  int nout;

  int  n_chk, n_fail;
  bit  finished;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int pcnt_of(input int k);
    return int'(priv_free_cnt[k*CW +: CW]);
  endfunction

  task automatic fill_model();
    for (int k = 0; k < NP; k++) begin
      for (int i = 0; i < PD; i++) pm[k][i] = k * PD + i;
      prd[k] = 0; pcnt[k] = PD;
    end
    for (int i = 0; i < SD; i++) sm[i] = SHB + i;
    srd = 0; scnt = SD;
    model_on = 1'b1;
  endtask

  // One cycle: drive at negedge, predict, check at following negedge.
  task automatic step(input bit req, input int port, input bit rv, input int raddr,
                      input string rq);
    int eg, er, ea, es;
    bit rdy;
    eg = 0; er = 0; ea = 0; es = 0;
    rdy = init_done;
    alloc_req  = req;
    alloc_port = PW'(port);
    rel_valid  = rv;
    rel_addr   = AW'(raddr);
    if (req) begin
      if (!rdy) er = 1;
      else if (pcnt[port] > 0) begin
        eg = 1; ea = pm[port][prd[port]];
        prd[port] = (prd[port] + 1) % PD; pcnt[port]--;
      end else if (scnt > 0) begin
        eg = 1; es = 1; ea = sm[srd];
        srd = (srd + 1) % SD; scnt--;
      end else er = 1;
    end
    if (rv && rdy) begin
      if (raddr < SHB) begin
        pm[raddr / PD][(prd[raddr / PD] + pcnt[raddr / PD]) % PD] = raddr;
        pcnt[raddr / PD]++;
      end else begin
        sm[(srd + scnt) % SD] = raddr;
        scnt++;
      end
    end
    @(posedge clk);
    #1;
    alloc_req = 1'b0;
    rel_valid = 1'b0;
    @(negedge clk);
    if (!model_on && init_done) fill_model();
    chk({rq, " gnt (R6)"}, int'(alloc_gnt), eg);
    chk({rq, " rej (R6)"}, int'(alloc_rej), er);
    if (eg != 0) begin
      chk({rq, " addr (R10)"}, int'(alloc_addr), ea);
      chk({rq, " shared flag"}, int'(alloc_shared), es);
      outl[nout] = ea; nout++;
    end
    if (model_on) begin
      for (int k = 0; k < NP; k++) chk({rq, " priv count (R9)"}, pcnt_of(k), pcnt[k]);
      chk({rq, " shared count (R9)"}, int'(shared_free_cnt), scnt);
    end
  endtask

  // Remove an outstanding address by index and return it
  function automatic int take_out(input int idx);
    int a;
    a = outl[idx];
    outl[idx] = outl[nout - 1];
    nout--;
    return a;
  endfunction

  function automatic int find_out(input int a);
    for (int i = 0; i < nout; i++) if (outl[i] == a) return i;
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc, a;
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0; nout = 0; model_on = 1'b0; finished = 1'b0;
    rst_n = 1'b0; alloc_req = 1'b0; rel_valid = 1'b0; alloc_port = '0; rel_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset gnt", int'(alloc_gnt), 0);
    chk("R1 reset rej", int'(alloc_rej), 0);
    chk("R1 reset done", int'(init_done), 0);
    rst_n = 1'b1;

    // Fill phase: requests refused, returns ignored (R2)
    cyc = 0;
    while (!init_done && cyc < 40) begin
      step(1'b1, cyc % NP, 1'b1, cyc % TOT, "R2 early");
      cyc++;
    end
    chk("R1 fill length", int'(cyc <= SD + 1), 1);
    chk("R1 done", int'(init_done), 1);
    chk("R2 ignored return port0", pcnt_of(0), PD);
    chk("R1 shared full", int'(shared_free_cnt), SD);

    // Drain reserved list 0 in order (R3, R10)
    for (int i = 0; i < PD; i++) begin
      step(1'b1, 0, 1'b0, 0, "R3 drain");
      chk("R3 range", int'(alloc_addr), i);
    end
    // Fallback to common list (R4)
    step(1'b1, 0, 1'b0, 0, "R4 fallback");
    chk("R4 shared addr", int'(alloc_addr), SHB);
    chk("R4 shared flag", int'(alloc_shared), 1);

    // Return into empty list while requesting same port (R8)
    a = take_out(find_out(3));
    step(1'b1, 0, 1'b1, a, "R8 empty");
    chk("R8 fallback shared", int'(alloc_shared), 1);
    chk("R8 priv0 refilled", pcnt_of(0), 1);
    a = take_out(find_out(5));
    step(1'b1, 0, 1'b1, a, "R8 same list");
    chk("R8 got returned addr", int'(alloc_addr), 3);
    chk("R8 count held", pcnt_of(0), 1);

    // Routing of returns (R7)
    a = take_out(find_out(SHB));
    step(1'b0, 0, 1'b1, a, "R7 shared return");
    chk("R7 shared count", int'(shared_free_cnt), SD - 1);
    step(1'b1, 2, 1'b0, 0, "R7 take port2");
    chk("R7 port2 addr", int'(alloc_addr), 2 * PD);
    a = take_out(find_out(2 * PD));
    step(1'b0, 0, 1'b1, a, "R7 port2 return");
    chk("R7 port2 count", pcnt_of(2), PD);

    // Exhaust port 0 and the common list, then reject (R5)
    for (int i = 0; i < SD + 4; i++) step(1'b1, 0, 1'b0, 0, "R5 exhaust");
    chk("R5 reject", int'(alloc_rej), 1);
    step(1'b1, 1, 1'b0, 0, "R3 other port");
    chk("R3 port1 private", int'(alloc_shared), 0);
    step(1'b0, 0, 1'b0, 0, "R6 idle");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit rq, rv;
      int ra;
      rq = ($urandom % 100) < 65;
      rv = (nout > 0) && (($urandom % 100) < 55);
      ra = 0;
      if (rv) ra = take_out(int'($urandom % nout));
      step(rq, int'($urandom % NP), rv, ra, "rand");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule